// File: doc/BRIEF.md
# Real-Mode Effective Address Generator

This block turns an already decoded memory operand into an address. It receives the two-bit addressing-mode field, the three-bit register/memory selector and a 16-bit displacement. It also receives the live values of the base register, the base pointer, the two index registers and the data and stack segment registers. From these it forms a 16-bit offset, picks the default segment and produces a 20-bit physical address.

The physical address is the segment value shifted left by four bit positions plus the offset. The stack segment is the default whenever the base pointer takes part in the offset. The data segment is used otherwise.

The block sits one register stage behind the operand decoder. A request offered with `req_valid` high comes out one clock later, either as a valid address or, for the register-operand mode, as a not-memory indication. The caller supplies the displacement already widened to 16 bits. An 8-bit displacement therefore reaches the block sign-extended.

Top module: `eag_unit`

## Requirements
- R1: Selector 000 gives offset base register + source index, and selector 001 gives base register + destination index, both with the data segment (`addr_stack`=0).
- R2: Selector 010 gives base pointer + source index, and selector 011 gives base pointer + destination index, both with the stack segment (`addr_stack`=1).
- R3: Selector 100 gives the source index, 101 the destination index and 111 the base register, each alone and each with the data segment.
- R4: Selector 110 with mode 01 or 10 gives base pointer + displacement with the stack segment.
- R5: Mode 00 with selector 110 gives the displacement alone as offset, with the data segment. The base pointer value has no effect in this case.
- R6: Mode 00 with any selector other than 110 adds no displacement. The displacement value has no effect on the output.
- R7: Mode 01 and mode 10 add the 16-bit displacement, taken as two's complement, to the register sum.
- R8: The offset sum wraps modulo 2^16 before the segment is applied.
- R9: `addr_phys` equals (segment × 16 + offset) modulo 2^20.
- R10: A request with `req_valid`=1 and mode other than 11 raises `addr_valid` exactly one clock later. A cycle without a request gives `addr_valid`=0 and `addr_notmem`=0 one clock later.
- R11: A request with mode 11 raises `addr_notmem` one clock later, and `addr_valid` stays 0 in that cycle.
- R12: A synchronous reset (`rst`=1 at a clock edge) leaves `addr_valid` and `addr_notmem` both 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A decoded operand is offered this cycle |
| req_mode | input | 2 | Addressing-mode field (00, 01, 10, 11) |
| req_rm | input | 3 | Register/memory selector |
| req_disp | input | 16 | Displacement, already widened to 16 bits |
| reg_bx | input | 16 | Base register value |
| reg_bp | input | 16 | Base pointer value |
| reg_si | input | 16 | Source index value |
| reg_di | input | 16 | Destination index value |
| seg_ds | input | 16 | Data segment value |
| seg_ss | input | 16 | Stack segment value |
| addr_valid | output | 1 | A memory address is presented |
| addr_notmem | output | 1 | The request was the register-operand mode |
| addr_offset | output | 16 | Effective offset |
| addr_stack | output | 1 | 1 when the stack segment was chosen |
| addr_phys | output | 20 | Physical address |

## Verification
The bench targets selector 110 under all three memory modes. A design that missed the direct-address exception would add the base pointer and choose the stack segment when mode is 00. The bench pairs extreme register values so that the offset sum and the segment sum both overflow. A design that carried into bit 16 of the offset would shift the physical address by 64 KiB.

The bench also feeds large displacements under mode 00, which a design that always added them would leak into the output. It places register-mode requests and idle cycles between memory requests. A wrong output-stage transition would then show a stale valid flag or a missing not-memory flag. Finally, the bench applies a reset in the cycle after a pending request, to confirm that the pending result is dropped.

// File: rtl/eag_pkg.sv
package eag_pkg;
    typedef enum logic [1:0] {
        BASE_NONE,
        BASE_BX,
        BASE_BP
    } base_pick_t;

    typedef enum logic [1:0] {
        IDX_NONE,
        IDX_SI,
        IDX_DI
    } idx_pick_t;

    typedef struct packed {
        base_pick_t base;
        idx_pick_t  idx;
        logic       use_disp;
        logic       stack_seg;
    } ea_plan_t;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_ADDR,
        ST_NOTMEM
    } stage_t;
endpackage

// File: rtl/eag_rm_decode.sv
module eag_rm_decode
    import eag_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [2:0] rm,
    output ea_plan_t   plan
);
    always_comb begin
        plan.base      = BASE_NONE;
        plan.idx       = IDX_NONE;
        plan.stack_seg = 1'b0;
        plan.use_disp  = (mode == 2'b01) || (mode == 2'b10);
        unique case (rm)
            3'b000: begin plan.base = BASE_BX; plan.idx = IDX_SI; end
            3'b001: begin plan.base = BASE_BX; plan.idx = IDX_DI; end
            3'b010: begin plan.base = BASE_BP; plan.idx = IDX_SI; plan.stack_seg = 1'b1; end
            3'b011: begin plan.base = BASE_BP; plan.idx = IDX_DI; plan.stack_seg = 1'b1; end
            3'b100: plan.idx = IDX_SI;
            3'b101: plan.idx = IDX_DI;
            3'b110: begin
                if (mode == 2'b00) begin
                    plan.use_disp = 1'b1;
                end else begin
                    plan.base      = BASE_BP;
                    plan.stack_seg = 1'b1;
                end
            end
            3'b111: plan.base = BASE_BX;
            default: plan.base = BASE_NONE;
        endcase
    end
endmodule

// File: rtl/eag_offset_sum.sv
module eag_offset_sum
    import eag_pkg::*;
#(
    parameter int OFS_W = 16
) (
    input  ea_plan_t           plan,
    input  logic [OFS_W-1:0]   bx,
    input  logic [OFS_W-1:0]   bp,
    input  logic [OFS_W-1:0]   si,
    input  logic [OFS_W-1:0]   di,
    input  logic [OFS_W-1:0]   disp,
    output logic [OFS_W-1:0]   offset
);
    logic [OFS_W-1:0] base_v, idx_v, disp_v;

    always_comb begin
        unique case (plan.base)
            BASE_BX: base_v = bx;
            BASE_BP: base_v = bp;
            default: base_v = '0;
        endcase
        unique case (plan.idx)
            IDX_SI:  idx_v = si;
            IDX_DI:  idx_v = di;
            default: idx_v = '0;
        endcase
        disp_v = plan.use_disp ? disp : '0;
        offset = base_v + idx_v + disp_v;
    end
endmodule

// File: rtl/eag_phys_sum.sv
module eag_phys_sum #(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = OFS_W + SEG_SHIFT
) (
    input  logic [OFS_W-1:0] seg,
    input  logic [OFS_W-1:0] offset,
    output logic [PA_W-1:0]  phys
);
    logic [PA_W-1:0] seg_ext, ofs_ext;

    always_comb begin
        seg_ext = PA_W'(seg) << SEG_SHIFT;
        ofs_ext = PA_W'(offset);
        phys    = seg_ext + ofs_ext;
    end
endmodule

// File: rtl/eag_unit.sv
module eag_unit
    import eag_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int PA_W     = OFS_W + SEG_SHIFT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_mode,
    input  logic [2:0]       req_rm,
    input  logic [OFS_W-1:0] req_disp,
    input  logic [OFS_W-1:0] reg_bx,
    input  logic [OFS_W-1:0] reg_bp,
    input  logic [OFS_W-1:0] reg_si,
    input  logic [OFS_W-1:0] reg_di,
    input  logic [OFS_W-1:0] seg_ds,
    input  logic [OFS_W-1:0] seg_ss,
    output logic             addr_valid,
    output logic             addr_notmem,
    output logic [OFS_W-1:0] addr_offset,
    output logic             addr_stack,
    output logic [PA_W-1:0]  addr_phys
);
    ea_plan_t         plan;
    logic [OFS_W-1:0] offset_c, seg_c, seg_q;
    logic [PA_W-1:0]  phys_c;
    stage_t           stage_q, stage_n;
    logic             is_mem;

    eag_rm_decode u_dec (
        .mode (req_mode),
        .rm   (req_rm),
        .plan (plan)
    );

    eag_offset_sum #(.OFS_W(OFS_W)) u_ofs (
        .plan   (plan),
        .bx     (reg_bx),
        .bp     (reg_bp),
        .si     (reg_si),
        .di     (reg_di),
        .disp   (req_disp),
        .offset (offset_c)
    );

    assign seg_c  = plan.stack_seg ? seg_ss : seg_ds;
    assign is_mem = (req_mode != 2'b11);

    eag_phys_sum #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
        .seg    (seg_c),
        .offset (offset_c),
        .phys   (phys_c)
    );

    // Next-state selection for the output stage
    always_comb begin
        if (!req_valid)  stage_n = ST_EMPTY;
        else if (is_mem) stage_n = ST_ADDR;
        else             stage_n = ST_NOTMEM;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) stage_q <= ST_EMPTY;
        else     stage_q <= stage_n;
    end

    // Data capture
    always_ff @(posedge clk) begin
        if (req_valid && is_mem) begin
            addr_offset <= offset_c;
            addr_stack  <= plan.stack_seg;
            addr_phys   <= phys_c;
            seg_q       <= seg_c;
        end
    end

    // Flags from the state
    always_comb begin
        addr_valid  = 1'b0;
        addr_notmem = 1'b0;
        unique case (stage_q)
            ST_ADDR:   addr_valid  = 1'b1;
            ST_NOTMEM: addr_notmem = 1'b1;
            default:   ;
        endcase
    end

    assert_mem_latency_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode != 2'b11) |=> (addr_valid && !addr_notmem));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!addr_valid && !addr_notmem));
    assert_regmode_flag_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 2'b11) |=> (addr_notmem && !addr_valid));
    assert_reset_clears_R12: assert property (@(posedge clk)
        rst |=> (!addr_valid && !addr_notmem));
    assert_direct_disp_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 2'b00 && req_rm == 3'b110)
            |=> (addr_offset == $past(req_disp) && !addr_stack));
    assert_phys_form_R9: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> (addr_phys == ((PA_W'(seg_q) << SEG_SHIFT) + PA_W'(addr_offset))));
endmodule

// File: tb/tb_eag_unit.sv
module tb_eag_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_mode = 2'b00;
    logic [2:0]  req_rm = 3'b000;
    logic [15:0] req_disp = '0;
    logic [15:0] reg_bx = 16'h1234, reg_bp = 16'h2000, reg_si = 16'h0010, reg_di = 16'h0300;
    logic [15:0] seg_ds = 16'h1000, seg_ss = 16'h3000;
    logic        addr_valid, addr_notmem, addr_stack;
    logic [15:0] addr_offset;
    logic [19:0] addr_phys;

    typedef struct {
        int          kind;  // 0 empty, 1 address, 2 not-memory
        logic [15:0] ofs;
        logic        stk;
        logic [19:0] phys;
        string       req;
    } exp_t;

    exp_t q[$];
    int   tests = 0, fails = 0;
    bit   done = 0;

    always #10 clk = ~clk;

    eag_unit dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_rm(req_rm), .req_disp(req_disp), .reg_bx(reg_bx), .reg_bp(reg_bp),
        .reg_si(reg_si), .reg_di(reg_di), .seg_ds(seg_ds), .seg_ss(seg_ss),
        .addr_valid(addr_valid), .addr_notmem(addr_notmem), .addr_offset(addr_offset),
        .addr_stack(addr_stack), .addr_phys(addr_phys)
    );

    function automatic exp_t model(input logic v, input logic [1:0] md, input logic [2:0] rm,
                                   input logic [15:0] d, input string tag);
        exp_t e;
        logic [15:0] o;
        logic        s;
        e.req = tag; e.ofs = '0; e.stk = 0; e.phys = '0;
        if (!v) begin e.kind = 0; return e; end
        if (md == 2'b11) begin e.kind = 2; return e; end
        e.kind = 1; s = 0;
        case (rm)
            3'd0: o = reg_bx + reg_si;
            3'd1: o = reg_bx + reg_di;
            3'd2: begin o = reg_bp + reg_si; s = 1; end
            3'd3: begin o = reg_bp + reg_di; s = 1; end
            3'd4: o = reg_si;
            3'd5: o = reg_di;
            3'd6: if (md == 2'b00) o = 16'h0; else begin o = reg_bp; s = 1; end
            default: o = reg_bx;
        endcase
        if (md != 2'b00 || rm == 3'd6) o = o + d;
        e.ofs = o; e.stk = s;
        e.phys = ({4'h0, (s ? seg_ss : seg_ds)} << 4) + {4'h0, o};
        return e;
    endfunction

    task automatic drive(input logic v, input logic [1:0] md, input logic [2:0] rm,
                         input logic [15:0] d, input logic r, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = v; req_mode = md; req_rm = rm; req_disp = d; rst = r;
        e = model(v, md, rm, d, tag);
        if (r) e.kind = 0;
        q.push_back(e);
    endtask

    // Monitor: compare after each edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            tests++;
            if (e.kind == 0 && (addr_valid || addr_notmem)) begin
                fails++;
                $display("FAIL %s: flags v=%0b n=%0b expected 0 0", e.req, addr_valid, addr_notmem);
            end else if (e.kind == 2 && (addr_valid || !addr_notmem)) begin
                fails++;
                $display("FAIL %s: flags v=%0b n=%0b expected 0 1", e.req, addr_valid, addr_notmem);
            end else if (e.kind == 1 && (!addr_valid || addr_notmem || addr_offset !== e.ofs ||
                         addr_stack !== e.stk || addr_phys !== e.phys)) begin
                fails++;
                $display("FAIL %s: v=%0b ofs=%h stk=%0b phys=%h expected v=1 ofs=%h stk=%0b phys=%h",
                         e.req, addr_valid, addr_offset, addr_stack, addr_phys, e.ofs, e.stk, e.phys);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        tests++;
        if (addr_valid || addr_notmem) begin
            fails++;
            $display("FAIL R12: reset flags v=%0b n=%0b expected 0 0", addr_valid, addr_notmem);
        end
        drive(0, 2'b00, 3'd0, 16'h0, 0, "R10 idle");
        drive(1, 2'b00, 3'd0, 16'hAAAA, 0, "R1 bx+si");
        drive(1, 2'b00, 3'd1, 16'h5555, 0, "R1 bx+di");
        drive(1, 2'b00, 3'd2, 16'h0, 0, "R2 bp+si");
        drive(1, 2'b00, 3'd3, 16'h0, 0, "R2 bp+di");
        drive(1, 2'b00, 3'd4, 16'hFFFF, 0, "R3 si");
        drive(1, 2'b00, 3'd5, 16'h0, 0, "R3 di");
        drive(1, 2'b00, 3'd7, 16'h0777, 0, "R6 bx no disp");
        drive(1, 2'b01, 3'd6, 16'h0022, 0, "R4 bp+d8");
        drive(1, 2'b10, 3'd6, 16'h1000, 0, "R4 bp+d16");
        drive(1, 2'b00, 3'd6, 16'h4321, 0, "R5 direct");
        drive(1, 2'b11, 3'd6, 16'h0, 0, "R11 regmode");
        drive(0, 2'b00, 3'd6, 16'h0, 0, "R10 idle after regmode");
        drive(1, 2'b01, 3'd5, 16'hFFFE, 0, "R7 negative disp");
        drive(1, 2'b10, 3'd0, 16'h0100, 0, "R7 bx+si+d16");
        drive(1, 2'b01, 3'd3, 16'h0033, 0, "R7 bp+di+d8");
        @(negedge clk);
        reg_bx = 16'hFFF0; reg_si = 16'h0020; reg_bp = 16'hFFFF;
        drive(1, 2'b00, 3'd0, 16'h0, 0, "R8 offset wrap");
        drive(1, 2'b10, 3'd2, 16'h8000, 0, "R8 triple wrap");
        drive(1, 2'b00, 3'd6, 16'hBEEF, 0, "R5 bp ignored");
        @(negedge clk);
        seg_ds = 16'hFFFF; seg_ss = 16'hF800;
        drive(1, 2'b00, 3'd0, 16'h0, 0, "R9 phys wrap ds");
        drive(1, 2'b10, 3'd6, 16'h8010, 0, "R9 phys wrap ss");
        drive(1, 2'b11, 3'd0, 16'h0, 0, "R11 back to back");
        drive(1, 2'b00, 3'd4, 16'h0, 0, "R10 after regmode");
        drive(1, 2'b01, 3'd1, 16'h0, 1, "R12 reset drops request");
        drive(0, 2'b00, 3'd0, 16'h0, 0, "R12 idle after reset");
        drive(1, 2'b10, 3'd7, 16'h0001, 0, "R10 resume");
        drive(0, 2'b00, 3'd0, 16'h0, 0, "R10 drain");
        repeat (3) @(posedge clk);
        #5;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule